// File: doc/BRIEF.md
# DMA Channel Address and Width Engine

This block is one DMA channel. After a start pulse it moves a programmed number of elements from a source region to a destination region over a memory port with a single-cycle handshake. At start it captures three things: the source and destination base addresses, the element count, and a set of control fields. Those fields choose how each side's address moves after an element (up, down or fixed) and how wide each side's element is. The two widths are independent, so one element read can be narrowed or widened before it is written. The channel never combines several reads into one write, and never splits one read into several writes.

In gather mode the source addresses are not computed from a base. A table pointer walks through 32-bit entries in memory. Each entry holds the source address of one element, so every element costs three accesses in this order: a table read, a data read and a data write. The destination still follows its own step rule.

A busy flag, a done flag and a count of remaining elements show progress. A start pulse that arrives while the channel is busy is dropped.

Top module: `dma_chan_engine`

## Requirements
- R1: The source address after each element is stepped by `src_mode`. Code 1 adds the source element size in bytes, code 2 subtracts it, and codes 0 and 3 leave it unchanged.
- R2: The destination address is stepped by `dst_mode` with the same codes, using the destination element size. It is independent of the source setting.
- R3: The size codes 0, 1, 2, 3 and 4 select elements of 8, 16, 32, 64 and 128 bits. Codes 5 to 7 act as 128 bits. Elements sit in the low bits of `mem_rdata`/`mem_wdata`, and `mem_size` carries the code of the side being accessed. Any source/destination pairing is allowed.
- R4: When the source element is wider than the destination element, the low-order destination-width bits of the source element are written.
- R5: When the source element is narrower, the bytes of the written element above the source width are zero. In every write, the `mem_wdata` bits above the destination width are zero.
- R6: Every data read is followed by exactly one write before the next element begins. A transfer of N elements makes N writes and N data reads.
- R7: With `gather_en` set, each element is fetched in three steps, in this order:
  - a 32-bit table read (size code 2) at the table pointer, whose low address bits give the source address;
  - a data read at that address;
  - the write.

  The table pointer starts at `tbl_base` and rises by 4 per element. `src_mode` has no effect in this mode.
- R8: `remaining` loads `xfer_count` on an accepted start and drops by one on each acknowledged write. Otherwise it holds its value.
- R9: `busy` rises in the cycle after an accepted start. In the cycle after `remaining` reaches zero, `busy` falls and `done` rises. `done` then stays high until the next accepted start, and is never high together with `busy`.
- R10: A start while busy has no effect. Base addresses, count and mode fields are captured only at an accepted start, so later changes to these inputs do not alter the running transfer.
- R11: A start with a count of zero makes no memory access. It raises `done` one cycle after `busy` rises.
- R12: After reset, `busy`, `done`, `remaining` and `mem_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| src_base | input | AW | First source address |
| dst_base | input | AW | First destination address |
| tbl_base | input | AW | First address-table entry (gather mode) |
| xfer_count | input | CW | Number of elements |
| src_mode | input | 2 | Source step: 0 hold, 1 up, 2 down, 3 hold |
| dst_mode | input | 2 | Destination step, same codes |
| src_size | input | 3 | Source element size code |
| dst_size | input | 3 | Destination element size code |
| gather_en | input | 1 | Take source addresses from the table |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| remaining | output | CW | Elements still to write |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 3 | Size code of the access |
| mem_wdata | output | 128 | Write element, low-aligned |
| mem_rdata | input | 128 | Read data, low-aligned, valid with ack |
| mem_ack | input | 1 | Access completes in this cycle |

## Verification
A byte-level memory model returns 16 bytes of live memory on every read, so unused upper read bits always carry noise. Because of this, a design that fails to mask the source width shows up as bad bytes in the destination region. Directed transfers cover three cases that together separate the two directions of width conversion and the two step directions:
- a full widening pair (8 to 128 bits);
- a full narrowing pair with a downward source;
- a fixed source feeding a downward destination.

Further directed runs cover a zero count, a gather table whose entries carry noise in their upper half, and a start pulse injected mid-transfer with every configuration input changed. Random transfers over all size pairs, modes, counts and acknowledge stalls are compared against a bench reference copy of the memory image, along with the read and write totals and the cycle in which `done` appears.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int ELEM_W     = 128;
    localparam int ELEM_BYTES = ELEM_W / 8;
    localparam int TBL_BYTES  = 4;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_RSVD = 2'd3
    } step_e;

    typedef enum logic [2:0] {
        SZ_8   = 3'd0,
        SZ_16  = 3'd1,
        SZ_32  = 3'd2,
        SZ_64  = 3'd3,
        SZ_128 = 3'd4
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TBL,
        ST_SRC,
        ST_DST,
        ST_FIN
    } state_e;

    typedef struct packed {
        step_e      src_step;
        step_e      dst_step;
        logic [2:0] src_size;
        logic [2:0] dst_size;
        logic       gather;
    } chan_cfg_t;

    // Bytes in one element of the given size code.
    function automatic logic [4:0] size_bytes(input logic [2:0] sz);
        case (sz)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    // Ones in the low bits covered by an element of the given size code.
    function automatic logic [ELEM_W-1:0] size_mask(input logic [2:0] sz);
        logic [ELEM_W-1:0] ones;
        ones = '1;
        return ones >> (ELEM_W - 8 * int'(size_bytes(sz)));
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_eng_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          adv,
    input  step_e         step,
    input  logic [2:0]    size,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] stride;
    logic [AW-1:0] addr_next;

    assign stride = AW'(size_bytes(size));

    always_comb begin
        case (step)
            STEP_INC: addr_next = addr + stride;
            STEP_DEC: addr_next = addr - stride;
            default:  addr_next = addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (adv) begin
            addr <= addr_next;
        end
    end

endmodule

// File: rtl/dma_elem_conv.sv
module dma_elem_conv
    import dma_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ELEM_W-1:0] rd_data,
    input  logic [2:0]        src_size,
    input  logic [2:0]        dst_size,
    output logic [ELEM_W-1:0] wr_data
);

    logic [ELEM_W-1:0] elem_q;

    // Hold only the source-width bits of the read; noise above is dropped.
    always_ff @(posedge clk) begin
        if (rst) begin
            elem_q <= '0;
        end else if (capture) begin
            elem_q <= rd_data & size_mask(src_size);
        end
    end

    // Narrowing keeps low bits; widening sees zeros already held above.
    assign wr_data = elem_q & size_mask(dst_size);

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_eng_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] count_in,
    input  chan_cfg_t     cfg_in,
    input  logic          mem_ack,
    output chan_cfg_t     cfg_q,
    output state_e        state,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] remaining,
    output logic          cfg_load,
    output logic          tbl_adv,
    output logic          src_from_tbl,
    output logic          src_adv,
    output logic          dst_adv,
    output logic          capture
);

    logic last_elem;

    assign last_elem = (remaining == CW'(1));
    assign busy      = (state != ST_IDLE);
    assign cfg_load  = (state == ST_IDLE) && start;

    assign tbl_adv      = (state == ST_TBL) && mem_ack;
    assign src_from_tbl = (state == ST_TBL) && mem_ack;
    assign capture      = (state == ST_SRC) && mem_ack;
    assign dst_adv      = (state == ST_DST) && mem_ack;
    assign src_adv      = (state == ST_DST) && mem_ack && !cfg_q.gather;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remaining <= '0;
            done      <= 1'b0;
            cfg_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q     <= cfg_in;
                        remaining <= count_in;
                        done      <= 1'b0;
                        if (count_in == '0) begin
                            state <= ST_FIN;
                        end else if (cfg_in.gather) begin
                            state <= ST_TBL;
                        end else begin
                            state <= ST_SRC;
                        end
                    end
                end
                ST_TBL: begin
                    if (mem_ack) state <= ST_SRC;
                end
                ST_SRC: begin
                    if (mem_ack) state <= ST_DST;
                end
                ST_DST: begin
                    if (mem_ack) begin
                        remaining <= remaining - CW'(1);
                        if (last_elem) begin
                            state <= ST_FIN;
                        end else if (cfg_q.gather) begin
                            state <= ST_TBL;
                        end else begin
                            state <= ST_SRC;
                        end
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_eng_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [AW-1:0] tbl_base,
    input  logic [CW-1:0] xfer_count,
    input  logic [1:0]    src_mode,
    input  logic [1:0]    dst_mode,
    input  logic [2:0]    src_size,
    input  logic [2:0]    dst_size,
    input  logic          gather_en,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] remaining,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [2:0]    mem_size,
    output logic [127:0]  mem_wdata,
    input  logic [127:0]  mem_rdata,
    input  logic          mem_ack
);

    localparam int TBL_AW = (AW < 32) ? AW : 32;

    chan_cfg_t     cfg_in;
    chan_cfg_t     cfg_q;
    state_e        state;
    logic          cfg_load, tbl_adv, src_from_tbl, src_adv, dst_adv, capture;
    logic          src_load;
    logic [AW-1:0] src_load_addr;
    logic [AW-1:0] src_addr, dst_addr, tbl_addr;

    assign cfg_in = '{
        src_step: step_e'(src_mode),
        dst_step: step_e'(dst_mode),
        src_size: src_size,
        dst_size: dst_size,
        gather:   gather_en
    };

    dma_chan_ctrl #(.CW(CW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .count_in     (xfer_count),
        .cfg_in       (cfg_in),
        .mem_ack      (mem_ack),
        .cfg_q        (cfg_q),
        .state        (state),
        .busy         (busy),
        .done         (done),
        .remaining    (remaining),
        .cfg_load     (cfg_load),
        .tbl_adv      (tbl_adv),
        .src_from_tbl (src_from_tbl),
        .src_adv      (src_adv),
        .dst_adv      (dst_adv),
        .capture      (capture)
    );

    // Source pointer: loaded from the base at start, or from a table entry.
    assign src_load      = cfg_load | src_from_tbl;
    assign src_load_addr = src_from_tbl ? AW'(mem_rdata[TBL_AW-1:0]) : src_base;

    dma_addr_step #(.AW(AW)) u_src_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (src_load),
        .load_addr (src_load_addr),
        .adv       (src_adv),
        .step      (cfg_q.src_step),
        .size      (cfg_q.src_size),
        .addr      (src_addr)
    );

    dma_addr_step #(.AW(AW)) u_dst_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .load_addr (dst_base),
        .adv       (dst_adv),
        .step      (cfg_q.dst_step),
        .size      (cfg_q.dst_size),
        .addr      (dst_addr)
    );

    dma_addr_step #(.AW(AW)) u_tbl_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .load_addr (tbl_base),
        .adv       (tbl_adv),
        .step      (STEP_INC),
        .size      (SZ_32),
        .addr      (tbl_addr)
    );

    dma_elem_conv u_conv (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .rd_data  (mem_rdata),
        .src_size (cfg_q.src_size),
        .dst_size (cfg_q.dst_size),
        .wr_data  (mem_wdata)
    );

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        mem_size = SZ_8;
        case (state)
            ST_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                mem_size = SZ_32;
            end
            ST_SRC: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
                mem_size = cfg_q.src_size;
            end
            ST_DST: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_addr;
                mem_size = cfg_q.dst_size;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk
    import dma_eng_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [2:0]    dst_size,
    input logic          gather_en,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] remaining,
    input logic          mem_req,
    input logic          mem_we,
    input logic [2:0]    mem_size,
    input logic [127:0]  mem_wdata,
    input logic          mem_ack
);

    logic [2:0] dsz_q;
    logic       gat_q;
    logic [1:0] rd_since;
    logic       wr_ack;
    logic       rd_ack;

    assign wr_ack = mem_req && mem_we && mem_ack;
    assign rd_ack = mem_req && !mem_we && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            dsz_q    <= '0;
            gat_q    <= 1'b0;
            rd_since <= '0;
        end else begin
            if (start && !busy) begin
                dsz_q <= dst_size;
                gat_q <= gather_en;
            end
            if (wr_ack) begin
                rd_since <= '0;
            end else if (rd_ack && rd_since != 2'd3) begin
                rd_since <= rd_since + 2'd1;
            end
        end
    end

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    assert_done_excl_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_ack) |=> $stable(remaining));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        wr_ack |=> (remaining == $past(remaining) - CW'(1)));

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ((mem_wdata & ~size_mask(dsz_q)) == '0));

    assert_write_size_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_size == dsz_q));

    assert_one_write_per_read_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (rd_since == (gat_q ? 2'd2 : 2'd1)));

    assert_table_first_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && gat_q && rd_since == 2'd0) |-> (!mem_we && mem_size == 3'd2));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .dst_size  (dst_size),
    .gather_en (gather_en),
    .busy      (busy),
    .done      (done),
    .remaining (remaining),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int MB = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0, tbl_base = '0;
    logic [CW-1:0] xfer_count = '0;
    logic [1:0]    src_mode = '0, dst_mode = '0;
    logic [2:0]    src_size = '0, dst_size = '0;
    logic          gather_en = 1'b0;
    logic          busy, done;
    logic [CW-1:0] remaining;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [2:0]    mem_size;
    logic [127:0]  mem_wdata, mem_rdata;

    logic [7:0]    mem    [MB];
    logic [7:0]    refm   [MB];
    logic          stall = 1'b0;
    logic          fill_req = 1'b0;
    logic          poke_en = 1'b0;
    logic [11:0]   poke_addr = '0;
    logic [7:0]    poke_data = '0;
    int            rd_cnt = 0, wr_cnt = 0;
    int            checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    dma_chan_engine #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .src_base(src_base), .dst_base(dst_base), .tbl_base(tbl_base),
        .xfer_count(xfer_count), .src_mode(src_mode), .dst_mode(dst_mode),
        .src_size(src_size), .dst_size(dst_size), .gather_en(gather_en),
        .busy(busy), .done(done), .remaining(remaining),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic int nbytes(input logic [2:0] sz);
        case (sz)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [15:0] stepped(input logic [15:0] a, input logic [1:0] m,
                                            input logic [2:0] sz);
        if (m == 2'd1) return a + 16'(nbytes(sz));
        if (m == 2'd2) return a - 16'(nbytes(sz));
        return a;
    endfunction

    assign mem_ack = mem_req & ~stall;

    // Read returns 16 live bytes, so bits above the element carry noise.
    always_comb begin
        for (int i = 0; i < 16; i++) begin
            mem_rdata[8*i +: 8] = mem[12'(mem_addr + 16'(i))];
        end
    end

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < MB; i++) mem[i] <= 8'($urandom);
        end else if (poke_en) begin
            mem[poke_addr] <= poke_data;
        end else if (mem_req && mem_ack) begin
            if (mem_we) begin
                for (int i = 0; i < 16; i++) begin
                    if (i < nbytes(mem_size)) mem[12'(mem_addr + 16'(i))] <= mem_wdata[8*i +: 8];
                end
                wr_cnt++;
            end else begin
                rd_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // Reference transfer on the bench copy of memory.
    task automatic model(input int cnt, input logic [15:0] sa0, input logic [15:0] da0,
                         input logic [15:0] ta0, input logic [1:0] sm, input logic [1:0] dm,
                         input logic [2:0] ss, input logic [2:0] ds, input bit g);
        logic [15:0] sa, da, ta, a;
        sa = sa0; da = da0; ta = ta0;
        for (int k = 0; k < cnt; k++) begin
            a = g ? {refm[12'(ta + 16'd1)], refm[12'(ta)]} : sa;
            ta = ta + 16'd4;
            for (int i = 0; i < nbytes(ds); i++) begin
                refm[12'(da + 16'(i))] = (i < nbytes(ss)) ? refm[12'(a + 16'(i))] : 8'h00;
            end
            if (!g) sa = stepped(sa, sm, ss);
            da = stepped(da, dm, ds);
        end
    endtask

    task automatic run(input int cnt, input logic [15:0] sa, input logic [15:0] da,
                       input logic [15:0] ta, input logic [1:0] sm, input logic [1:0] dm,
                       input logic [2:0] ss, input logic [2:0] ds, input bit g,
                       input bit restart_busy);
        int  rd0, wr0, bad, cyc;
        bit  seen_zero, finished;
        if (g) begin
            for (int k = 0; k < cnt; k++) begin
                logic [15:0] ent;
                ent = 16'h0400 + 16'($urandom_range(0, 16'h02F0));
                poke(12'(ta + 16'(4*k)),     ent[7:0]);
                poke(12'(ta + 16'(4*k + 1)), ent[15:8]);
                poke(12'(ta + 16'(4*k + 2)), 8'($urandom)); // upper half is noise
                poke(12'(ta + 16'(4*k + 3)), 8'($urandom));
            end
        end
        @(negedge clk);
        for (int i = 0; i < MB; i++) refm[i] = mem[i];
        rd0 = rd_cnt; wr0 = wr_cnt;
        src_base = sa; dst_base = da; tbl_base = ta; xfer_count = CW'(cnt);
        src_mode = sm; dst_mode = dm; src_size = ss; dst_size = ds; gather_en = g;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R9 busy after start", {busy, done}, 2'b10);
        chk(remaining == CW'(cnt), "R8 count loaded", remaining, cnt);
        // Scramble every configuration input; the latched copy must win (R10).
        src_base = 16'h0F00; dst_base = 16'h0F80; tbl_base = 16'h0000;
        xfer_count = CW'(3); src_mode = 2'd2; dst_mode = 2'd2;
        src_size = 3'd4; dst_size = 3'd4; gather_en = ~g;
        seen_zero = (remaining == '0);
        finished = 1'b0;
        cyc = 0;
        while (!finished && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (restart_busy && cyc == 3 && busy) start = 1'b1;
            else start = 1'b0;
            if (seen_zero) begin
                chk(done == 1'b1 && busy == 1'b0, "R9 done one cycle after zero",
                    {busy, done}, 2'b01);
                finished = 1'b1;
            end else if (busy && remaining == '0) begin
                seen_zero = 1'b1;
            end
        end
        start = 1'b0;
        chk(finished, "R9 transfer completes", finished, 1);
        model(cnt, sa, da, ta, sm, dm, ss, ds, g);
        bad = 0;
        for (int i = 0; i < MB; i++) begin
            if (mem[i] !== refm[i]) begin
                if (bad == 0)
                    $display("FAIL R1 R2 R3 R4 R5 R7 R10 byte %0h actual=%0h expected=%0h",
                             i, mem[i], refm[i]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
        chk(wr_cnt - wr0 == cnt, "R6 write count", wr_cnt - wr0, cnt);
        chk(rd_cnt - rd0 == (g ? 2*cnt : cnt), "R6 R7 read count", rd_cnt - rd0,
            g ? 2*cnt : cnt);
        chk(remaining == '0, "R8 count at end", remaining, 0);
        repeat (2) @(negedge clk);
        chk(!busy && done && wr_cnt - wr0 == cnt, "R10 no restart after done",
            {busy, done}, 2'b01);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        fill_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && remaining == 0 && mem_req == 0, "R12 reset state",
            {busy, done, mem_req}, 0);

        // Directed corner cases.
        run(3, 16'h0500, 16'h0900, 16'h0100, 2'd1, 2'd1, 3'd0, 3'd4, 1'b0, 1'b0); // R5 widen
        run(4, 16'h0580, 16'h0900, 16'h0100, 2'd2, 2'd1, 3'd4, 3'd0, 1'b0, 1'b0); // R4 R1 narrow, down
        run(5, 16'h0500, 16'h0980, 16'h0100, 2'd0, 2'd2, 3'd2, 3'd3, 1'b0, 1'b0); // R1 hold, R2 down
        run(4, 16'h0500, 16'h0900, 16'h0100, 2'd3, 2'd0, 3'd1, 3'd1, 1'b0, 1'b0); // R1 code 3 holds
        run(0, 16'h0500, 16'h0900, 16'h0100, 2'd1, 2'd1, 3'd2, 3'd2, 1'b0, 1'b0); // R11 zero count
        run(0, 16'h0500, 16'h0900, 16'h0100, 2'd1, 2'd1, 3'd2, 3'd2, 1'b1, 1'b0); // R11 gather zero
        run(6, 16'h0000, 16'h0900, 16'h0120, 2'd2, 2'd1, 3'd3, 3'd2, 1'b1, 1'b0); // R7 gather
        run(5, 16'h0500, 16'h0900, 16'h0100, 2'd1, 2'd1, 3'd2, 3'd2, 1'b0, 1'b1); // R10 restart
        run(3, 16'h0500, 16'h0900, 16'h0100, 2'd1, 2'd1, 3'd7, 3'd5, 1'b0, 1'b0); // R3 codes 5-7

        // Random transfers with random acknowledge stalls.
        for (int t = 0; t < 30; t++) begin
            run($urandom_range(0, 8), 16'h0500, 16'h0900, 16'h0100 + 16'(4 * $urandom_range(0, 8)),
                2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                3'($urandom_range(0, 4)), 3'($urandom_range(0, 4)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (!rst) stall <= ($urandom_range(0, 3) == 0);
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule